// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block is the timekeeping core of a real-time clock. An enable pulse at oscillator rate goes through a programmable divider. Every `TICKS_PER_SEC` accepted pulses it produces one increment of the seconds field. A carry chain passes that increment on to the minutes, hours, day-of-week, date, month and year fields. All of these fields are held in packed BCD, and the clock runs in 24-hour form only. The hours byte also carries two century flags: an enable and a century bit. The century bit toggles when the year wraps past 99, but only while the enable is set.

A host-side register block writes the fields through a shared byte bus with one load strobe per field. It reads them back as seven byte-wide register images. Bit 7 of the seconds image is a stop bit: when it is set, the divider freezes and no field advances. Writing the seconds field also restarts the sub-second divider, so the next second boundary lands a full period after the write. Loading values that are not valid BCD, or that are outside a field's range, gives undefined results, and the block makes no attempt to correct them.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the images read seconds 00, minutes 00, hours 00 with both century flags 0, day-of-week 1, date 01, month 01 and year 00, and the stop bit is 0.
- R2: While running, the seconds field advances by one only on the `TICKS_PER_SEC`-th accepted tick. A cycle with `tick_i` low neither counts nor advances anything.
- R3: Seconds wrap from 59 to 00 and advance minutes. Minutes wrap from 59 to 00 and advance hours. Hours wrap from 23 to 00 and advance both date and day-of-week.
- R4: Day-of-week counts from 1 up to `DOW_MAX` (default 7) and then returns to 1 at the next midnight.
- R5: The date wraps to 01 after 28 days in February (29 when the BCD year is a multiple of four), after 30 days in April, June, September and November, and after 31 days in the other months. At that wrap the month advances, and when the month wraps from 12 to 01 the year advances and wraps from 99 to 00.
- R6: The hours image holds the century enable in bit 7 and the century bit in bit 6. On a year wrap from 99 to 00 the century bit toggles if the enable is 1 and holds if it is 0. At no other time does it change, apart from a hours load.
- R7: Bit 7 of the seconds image is the stop bit, written through bit 7 of a seconds load. While it is 1, no field changes unless it is loaded.
- R8: A seconds load clears the divider. The next increment comes on exactly the `TICKS_PER_SEC`-th tick after the load.
- R9: `ld_en_i` bit 0 is seconds, 1 is minutes, 2 is hours, 3 is day-of-week, 4 is date, 5 is month and 6 is year. A field whose strobe is set takes `ld_data_i` at the next edge instead of incrementing. That field then passes no carry to the next field in that cycle.
- R10: A hours load stores `ld_data_i[5:0]` as the hour and `ld_data_i[7:6]` as the century enable and century bit, and all three read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Oscillator-rate enable, one accepted tick per high cycle |
| ld_en_i | input | 7 | Per-field load strobes (bit mapping in R9) |
| ld_data_i | input | 8 | Shared load byte |
| sec_o | output | 8 | Stop bit in bit 7, BCD seconds in bits 6:0 |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century enable, century bit, BCD hours in bits 5:0 |
| dow_o | output | 8 | Day-of-week, 1 to `DOW_MAX` |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 4 and `DOW_MAX` left at 7. With that setting a simulated second lasts four cycles. This makes it cheap to free-run through minute rollovers. It also makes it cheap to preload the last second of the day before the last and last day of every month, in a normal year, a leap year, year 00 and year 99, and then cross into the next day. The short period also lets the bench line the divider up with a load in the same cycle, with the stop bit, and with century wraps for all four combinations of the century flags. A cycle-by-cycle arithmetic model in the bench is compared against every output after each edge.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

   localparam int NUM_FIELDS = 7;
   localparam int F_SEC   = 0;
   localparam int F_MIN   = 1;
   localparam int F_HOUR  = 2;
   localparam int F_DOW   = 3;
   localparam int F_DATE  = 4;
   localparam int F_MONTH = 5;
   localparam int F_YEAR  = 6;

   // storage width of each BCD field
   function automatic int field_width(input int f);
      case (f)
         F_SEC, F_MIN:   return 7;
         F_HOUR, F_DATE: return 6;
         F_DOW:          return 3;
         F_MONTH:        return 5;
         default:        return 8;
      endcase
   endfunction

   // value a field returns to after wrapping (and resets to)
   function automatic int field_floor(input int f);
      case (f)
         F_DOW, F_DATE, F_MONTH: return 1;
         default:                return 0;
      endcase
   endfunction

   // fixed top value of a field; the date is handled separately
   function automatic logic [7:0] field_ceiling(input int f, input int dow_last);
      case (f)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DOW:        return 8'(dow_last);
         F_MONTH:      return 8'h12;
         F_YEAR:       return 8'h99;
         default:      return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] bcd_succ(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // a packed-BCD year is a multiple of four when an even tens digit
   // meets units 0/4/8 or an odd tens digit meets units 2/6
   function automatic logic leap_year(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
`timescale 1ns/1ps
module rtc_tick_divider #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic halt_i,
   input  logic clear_i,
   output logic sec_pulse_o
);
   localparam int               CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(TICKS_PER_SEC - 1);
   localparam bit               POW2  = ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic             advance;

   if (TICKS_PER_SEC < 2) begin : g_bad_tps
      $error("rtc_tick_divider: TICKS_PER_SEC must be at least 2");
   end

   assign advance     = tick_i & ~halt_i;
   assign sec_pulse_o = advance & ~clear_i & (cnt_q == LAST);

   if (POW2) begin : g_pow2
      // counter wraps on its own width
      always_ff @(posedge clk) begin
         if (!rst_n || clear_i) cnt_q <= '0;
         else if (advance)      cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_modn
      always_ff @(posedge clk) begin
         if (!rst_n || clear_i) cnt_q <= '0;
         else if (advance)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field #(
   parameter int W     = 8,
   parameter int FLOOR = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic [7:0]   ceil_i,
   output logic [W-1:0] val_o,
   output logic         at_ceil_o
);
   localparam logic [W-1:0] FLOOR_V = W'(FLOOR);

   logic [W-1:0] nxt;

   if (W < 3 || W > 8) begin : g_bad_w
      $error("rtc_bcd_field: W must lie in 3..8");
   end

   assign at_ceil_o = (8'(val_o) == ceil_i);

   always_comb begin
      if (at_ceil_o) nxt = FLOOR_V;
      else           nxt = W'(rtc_cal_pkg::bcd_succ(8'(val_o)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     val_o <= FLOOR_V;
      else if (ld_i)  val_o <= ld_val_i;
      else if (inc_i) val_o <= nxt;
   end

endmodule

// File: rtl/rtc_century_flags.sv
`timescale 1ns/1ps
module rtc_century_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_i,
   input  logic ld_enable_i,
   input  logic ld_bit_i,
   input  logic year_wrap_i,
   output logic enable_o,
   output logic bit_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_o <= 1'b0;
         bit_o    <= 1'b0;
      end else if (ld_i) begin
         enable_o <= ld_enable_i;
         bit_o    <= ld_bit_i;
      end else if (year_wrap_i && enable_o) begin
         bit_o    <= ~bit_o;
      end
   end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int DOW_MAX       = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic [NUM_FIELDS-1:0] ld_en_i,
   input  logic [7:0]            ld_data_i,
   output logic [7:0]            sec_o,
   output logic [7:0]            min_o,
   output logic [7:0]            hour_o,
   output logic [7:0]            dow_o,
   output logic [7:0]            date_o,
   output logic [7:0]            month_o,
   output logic [7:0]            year_o
);
   if (DOW_MAX < 2 || DOW_MAX > 7) begin : g_bad_dow
      $error("rtc_calendar_core: DOW_MAX must lie in 2..7");
   end

   logic                  halt_q;
   logic                  sec_pulse;
   logic                  year_roll;
   logic                  cen_en;
   logic                  cen_bit;
   logic [NUM_FIELDS-1:0] step;
   logic [NUM_FIELDS-1:0] at_ceil;
   logic [7:0]            cur [NUM_FIELDS];

   // stop bit rides on bit 7 of a seconds load
   always_ff @(posedge clk) begin
      if (!rst_n)              halt_q <= 1'b0;
      else if (ld_en_i[F_SEC]) halt_q <= ld_data_i[7];
   end

   rtc_tick_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .halt_i     (halt_q),
      .clear_i    (ld_en_i[F_SEC]),
      .sec_pulse_o(sec_pulse)
   );

   // single-cycle carry chain; a loaded field passes no carry
   always_comb begin
      logic c;
      logic mid;
      step          = '0;
      c             = sec_pulse;
      step[F_SEC]   = c;
      c             = c & ~ld_en_i[F_SEC] & at_ceil[F_SEC];
      step[F_MIN]   = c;
      c             = c & ~ld_en_i[F_MIN] & at_ceil[F_MIN];
      step[F_HOUR]  = c;
      mid           = c & ~ld_en_i[F_HOUR] & at_ceil[F_HOUR];
      step[F_DOW]   = mid;
      step[F_DATE]  = mid;
      c             = mid & ~ld_en_i[F_DATE] & at_ceil[F_DATE];
      step[F_MONTH] = c;
      c             = c & ~ld_en_i[F_MONTH] & at_ceil[F_MONTH];
      step[F_YEAR]  = c;
      year_roll     = c & ~ld_en_i[F_YEAR] & at_ceil[F_YEAR];
   end

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      localparam int FW = field_width(g);
      logic [7:0]    lim;
      logic [FW-1:0] val;

      if (g == F_DATE) begin : g_lim_cal
         assign lim = month_days(cur[F_MONTH], cur[F_YEAR]);
      end else begin : g_lim_fix
         assign lim = field_ceiling(g, DOW_MAX);
      end

      rtc_bcd_field #(.W(FW), .FLOOR(field_floor(g))) u_fld (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_i    (step[g]),
         .ld_i     (ld_en_i[g]),
         .ld_val_i (ld_data_i[FW-1:0]),
         .ceil_i   (lim),
         .val_o    (val),
         .at_ceil_o(at_ceil[g])
      );

      assign cur[g] = 8'(val);
   end

   rtc_century_flags u_cen (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_i       (ld_en_i[F_HOUR]),
      .ld_enable_i(ld_data_i[7]),
      .ld_bit_i   (ld_data_i[6]),
      .year_wrap_i(year_roll),
      .enable_o   (cen_en),
      .bit_o      (cen_bit)
   );

   assign sec_o   = cur[F_SEC]  | {halt_q, 7'b0};
   assign hour_o  = cur[F_HOUR] | {cen_en, cen_bit, 6'b0};
   assign min_o   = cur[F_MIN];
   assign dow_o   = cur[F_DOW];
   assign date_o  = cur[F_DATE];
   assign month_o = cur[F_MONTH];
   assign year_o  = cur[F_YEAR];

endmodule

// File: rtl/rtc_calendar_core_chk.sv
`timescale 1ns/1ps
module rtc_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic [6:0] ld_en_i,
   input logic [7:0] ld_data_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] dow_o,
   input logic [7:0] date_o,
   input logic [7:0] month_o,
   input logic [7:0] year_o
);
   AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && ld_en_i == 7'd0) |=> $stable(sec_o)); // R2

   AST_MIN_WAITS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i == 7'd0 && sec_o[6:0] != 7'h59) |=> $stable(min_o)); // R3

   AST_DAY_WAITS_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i == 7'd0 && hour_o[5:0] != 6'h23) |=> ($stable(date_o) && $stable(dow_o))); // R3

   AST_CENTURY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i == 7'd0 && !hour_o[7]) |=> $stable(hour_o[6])); // R6

   AST_CENTURY_NEEDS_Y99: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i == 7'd0 && year_o != 8'h99) |=> $stable(hour_o[6])); // R6

   AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i == 7'd0 && sec_o[7]) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
         && $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o))); // R7

   AST_SEC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i[0] |=> (sec_o == $past(ld_data_i))); // R9

   AST_MONTH_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i[5] |=> (month_o == {3'b000, $past(ld_data_i[4:0])})); // R9
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .ld_en_i  (ld_en_i),
   .ld_data_i(ld_data_i),
   .sec_o    (sec_o),
   .min_o    (min_o),
   .hour_o   (hour_o),
   .dow_o    (dow_o),
   .date_o   (date_o),
   .month_o  (month_o),
   .year_o   (year_o)
);

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
   localparam int TPS  = 4;
   localparam int DOWM = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [6:0] ld_en_i = 7'd0;
   logic [7:0] ld_data_i = 8'd0;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

   int  compared = 0;
   int  mismatched = 0;
   bit  finished = 1'b0;

   // arithmetic model, binary values
   int  m_div, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
   bit  m_halt, m_ceb, m_cb;

   always #2.5 clk = ~clk;

   rtc_calendar_core #(.TICKS_PER_SEC(TPS), .DOW_MAX(DOWM)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ld_en_i(ld_en_i), .ld_data_i(ld_data_i),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
      .date_o(date_o), .month_o(month_o), .year_o(year_o));

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int mdays(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "sec",   sec_o,   {m_halt, i2b(m_sec)[6:0]});
      chk(tag, "min",   min_o,   i2b(m_min));
      chk(tag, "hour",  hour_o,  {m_ceb, m_cb, i2b(m_hr)[5:0]});
      chk(tag, "dow",   dow_o,   8'(m_dow));
      chk(tag, "date",  date_o,  i2b(m_date));
      chk(tag, "month", month_o, i2b(m_mon));
      chk(tag, "year",  year_o,  i2b(m_yr));
   endtask

   // drive one cycle (called at a falling edge), advance the model, compare
   task automatic step(input logic tk, input logic [6:0] en, input logic [7:0] d, input string tag);
      bit pulse, c_min, c_hr, mid, c_mon, c_yr, y_wrap;
      int dim;
      tick_i = tk; ld_en_i = en; ld_data_i = d;
      pulse  = tk && !m_halt && (m_div == TPS - 1) && !en[0];
      c_min  = pulse && m_sec == 59;
      c_hr   = c_min && !en[1] && m_min == 59;
      mid    = c_hr && !en[2] && m_hr == 23;
      dim    = mdays(m_mon, m_yr);
      c_mon  = mid && !en[4] && m_date == dim;
      c_yr   = c_mon && !en[5] && m_mon == 12;
      y_wrap = c_yr && !en[6] && m_yr == 99;
      if (en[0]) m_div = 0;
      else if (tk && !m_halt) m_div = (m_div == TPS - 1) ? 0 : m_div + 1;
      if (en[0]) begin m_sec = b2i({1'b0, d[6:0]}); m_halt = d[7]; end
      else if (pulse) m_sec = (m_sec + 1) % 60;
      if (en[1]) m_min = b2i({1'b0, d[6:0]}); else if (c_min) m_min = (m_min + 1) % 60;
      if (en[2]) begin m_hr = b2i({2'b0, d[5:0]}); m_ceb = d[7]; m_cb = d[6]; end
      else begin
         if (c_hr) m_hr = (m_hr + 1) % 24;
         if (y_wrap && m_ceb) m_cb = !m_cb;
      end
      if (en[3]) m_dow = int'(d[2:0]); else if (mid) m_dow = (m_dow == DOWM) ? 1 : m_dow + 1;
      if (en[4]) m_date = b2i({2'b0, d[5:0]}); else if (mid) m_date = (m_date == dim) ? 1 : m_date + 1;
      if (en[5]) m_mon = b2i({3'b0, d[4:0]}); else if (c_mon) m_mon = (m_mon == 12) ? 1 : m_mon + 1;
      if (en[6]) m_yr = b2i(d); else if (c_yr) m_yr = (m_yr + 1) % 100;
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic load(input int idx, input logic [7:0] d, input string tag);
      step(1'b0, 7'(1 << idx), d, tag);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) step(1'b1, 7'd0, 8'd0, tag);
   endtask

   // preload a full date and time, seconds last
   task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                          input logic [7:0] s, input string tag);
      load(6, y, tag);  load(5, mo, tag); load(4, dt, tag); load(3, dw, tag);
      load(2, hr, tag); load(1, mi, tag); load(0, s, tag);
   endtask

   initial begin
      m_div = 0; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
      m_halt = 0; m_ceb = 0; m_cb = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      // R2 / R3: free run across several minute boundaries
      run(300, "R2");
      // R2: sparse ticks
      for (int k = 0; k < 90; k++) step(k % 3 == 1, 7'd0, 8'd0, "R2");

      // R3: crossing midnight
      set_all(8'h23, 8'h05, 8'h14, 8'h02, 8'h23, 8'h59, 8'h58, "R3");
      run(2 * TPS + 2, "R3");
      chk("R3", "midnight date", date_o, 8'h15);
      chk("R3", "midnight hour", hour_o, 8'h00);

      // R4: day-of-week wrap
      set_all(8'h23, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59, "R4");
      run(TPS, "R4");
      chk("R4", "dow wrap", dow_o, 8'h01);

      // R5: last two days of every month, several years
      for (int yi = 0; yi < 4; yi++) begin
         int yv;
         yv = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
         for (int mo = 1; mo <= 12; mo++) begin
            for (int back = 1; back >= 0; back--) begin
               set_all(i2b(yv), i2b(mo), i2b(mdays(mo, yv) - back), 8'(1 + mo % DOWM),
                       8'h23, 8'h59, 8'h59, "R5");
               run(TPS + 1, "R5");
            end
         end
      end
      set_all(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, "R5");
      run(TPS, "R5");
      chk("R5", "leap feb 29", date_o, 8'h29);
      set_all(8'h25, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, "R5");
      run(TPS, "R5");
      chk("R5", "feb to mar", month_o, 8'h03);

      // R6: century wrap with all enable/bit pairs
      for (int f = 0; f < 4; f++) begin
         logic e, b;
         e = f[1]; b = f[0];
         set_all(8'h99, 8'h12, 8'h31, 8'h03, {e, b, 6'h23}, 8'h59, 8'h59, "R6");
         run(TPS, "R6");
         chk("R6", "century bits", hour_o, {e, e ? ~b : b, 6'h00});
         chk("R6", "year wrap", year_o, 8'h00);
      end

      // R7: stop bit
      load(0, 8'h90, "R7");
      run(3 * TPS, "R7");
      chk("R7", "stopped sec", sec_o, 8'h90);
      load(0, 8'h10, "R7");
      run(TPS, "R7");
      chk("R7", "restarted sec", sec_o, 8'h11);

      // R8: seconds write restarts the divider
      run(2, "R8");
      load(0, 8'h30, "R8");
      run(TPS - 1, "R8");
      chk("R8", "sec before period", sec_o, 8'h30);
      run(1, "R8");
      chk("R8", "sec at period", sec_o, 8'h31);

      // R9: load beats a same-cycle increment
      load(1, 8'h20, "R9");
      load(0, 8'h59, "R9");
      run(TPS - 1, "R9");
      step(1'b1, 7'b0000010, 8'h42, "R9");
      chk("R9", "min load over carry", min_o, 8'h42);
      chk("R9", "sec wrapped", sec_o, 8'h00);
      load(0, 8'h58, "R9");
      run(TPS + TPS - 1, "R9");
      step(1'b1, 7'b0000001, 8'h07, "R9");
      chk("R9", "sec load no carry", min_o, 8'h42);
      chk("R9", "sec loaded", sec_o, 8'h07);

      // R10: hours byte with century flags
      load(2, 8'hC5, "R10");
      chk("R10", "hour C5", hour_o, 8'hC5);
      load(2, 8'h45, "R10");
      chk("R10", "hour 45", hour_o, 8'h45);
      load(2, 8'h17, "R10");
      chk("R10", "hour 17", hour_o, 8'h17);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual running expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule